// File: doc/BRIEF.md
# Byte-Wide GPIO Register Bank

This block holds the state of an eight-pin general-purpose I/O port behind a
small register file. A serial front end, outside this block, decodes bus
transfers into a 2-bit register pointer, a one-cycle write strobe with a data
byte, and a one-cycle read request. The bank answers reads with a registered
data byte. It drives a per-pin output value and output enable toward the pads,
and it samples the pad levels through a synchronizer.

Four registers are reachable. The first is a read-only image of the pin levels.
The second is the output latch. The third is a polarity mask that applies to
the pin image on readback. The fourth is a direction mask. One pin position can
be built as an open-drain output, which only sinks current or floats; the
other pins drive both levels.

Two resets return every register to its default. The first is an asynchronous
active-low input, which keeps the bank at the defaults for as long as it is
held low. The second is a synchronous clear.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the output latch is 0x00, the polarity mask is 0xF0 and the direction mask is 0xFF. Every pin_oe bit is 0, and rdata is 0x00.
- R2: The value of ptr picks the register for both reads and writes: 0 is the pin image, 1 is the output latch, 2 is the polarity mask and 3 is the direction mask.
- R3: A direction bit of 1 makes its pin an input, with pin_oe low. A direction bit of 0 on a push-pull pin (bits 7..1) sets pin_oe high, and pin_out then follows the output latch bit.
- R4: The pin image holds the pin_in levels from three clock edges earlier: two synchronizer stages plus the image register. This holds for every pin, whatever its direction.
- R5: A read of register 0 returns the pin image XOR the polarity mask. A mask bit of 1 inverts that bit, and a mask bit of 0 passes it through unchanged.
- R6: A write with ptr = 0 changes no register and has no effect on pin_oe or pin_out.
- R7: A read of register 1 returns the latched output byte, not the levels on pin_in.
- R8: Pin 0 is open-drain. pin_out[0] is always 0. pin_oe[0] is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R9: While rst_n is low, all registers and rdata sit at the R1 values. This takes effect without waiting for a clock edge.
- R10: srst high at a clock edge restores the R1 values at that edge, and it overrides a write or read in the same cycle.
- R11: rdata is updated at the edge that samples rd_en high, using register contents from before that edge. With rd_en low it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous clear to defaults |
| wr_en | input | 1 | Write strobe for the byte on wdata |
| rd_en | input | 1 | Read request; rdata loads at this edge |
| ptr | input | 2 | Register pointer |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Levels sampled from the pads |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
The bench builds the bank with its defaults: eight pins, a two-stage synchronizer, polarity reset 0xF0 and the open-drain pin at position 0. This makes the three-edge pin-to-image latency a fixed value the reference model can track. It also places both the open-drain rule and the mixed polarity reset inside the same byte. With bit 0 of the output latch toggled while every pin is an output, the open-drain pin floats and sinks in turn while its push-pull neighbours drive high. Reading the pin image under polarity masks 0xF0, 0x00 and 0xFF covers both inverted and pass-through bits on every pin.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PTR_W = 2;

    typedef enum logic [PTR_W-1:0] {
        SEL_PINS = 2'd0,
        SEL_LATCH = 2'd1,
        SEL_INVERT = 2'd2,
        SEL_DIR = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        for (int s = 0; s < STAGES; s++) begin
            if (srst)
                stage_d[s] = '0;
            else if (s == 0)
                stage_d[s] = async_in;
            else
                stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int           W       = 8,
    parameter logic [W-1:0] OD_MASK = 8'h01
) (
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] latch,
    output logic [W-1:0] drive_val,
    output logic [W-1:0] drive_en
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        if (OD_MASK[i]) begin : g_od
            // Sink-only: enable the pull-down when the output wants a 0
            assign drive_en[i]  = ~dir_in[i] & ~latch[i];
            assign drive_val[i] = 1'b0;
        end else begin : g_pp
            assign drive_en[i]  = ~dir_in[i];
            assign drive_val[i] = latch[i];
        end
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
#(
    parameter int           W        = 8,
    parameter int           SYNC     = 2,
    parameter logic [W-1:0] OUT_RST  = '0,
    parameter logic [W-1:0] POL_RST  = 8'hF0,
    parameter logic [W-1:0] DIR_RST  = '1,
    parameter logic [W-1:0] OD_MASK  = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] ptr,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] invert;
        logic [W-1:0] dir;
        logic [W-1:0] image;
        logic [W-1:0] rd;
    } bank_t;

    localparam bank_t BANK_RST = '{
        latch:  OUT_RST,
        invert: POL_RST,
        dir:    DIR_RST,
        image:  '0,
        rd:     '0
    };

    bank_t        bank_d, bank_q;
    logic [W-1:0] pins_sync;
    logic [W-1:0] rd_mux;

    gpio_sync #(.W(W), .STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    always_comb begin
        unique case (reg_sel_e'(ptr))
            SEL_PINS:   rd_mux = bank_q.image ^ bank_q.invert;
            SEL_LATCH:  rd_mux = bank_q.latch;
            SEL_INVERT: rd_mux = bank_q.invert;
            SEL_DIR:    rd_mux = bank_q.dir;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        bank_d = bank_q;
        if (srst) begin
            bank_d = BANK_RST;
        end else begin
            bank_d.image = pins_sync;
            if (wr_en) begin
                unique case (reg_sel_e'(ptr))
                    SEL_LATCH:  bank_d.latch  = wdata;
                    SEL_INVERT: bank_d.invert = wdata;
                    SEL_DIR:    bank_d.dir    = wdata;
                    default:    ;
                endcase
            end
            if (rd_en) bank_d.rd = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= BANK_RST;
        else        bank_q <= bank_d;
    end

    gpio_pad_ctrl #(.W(W), .OD_MASK(OD_MASK)) u_pad (
        .dir_in    (bank_q.dir),
        .latch     (bank_q.latch),
        .drive_val (pin_out),
        .drive_en  (pin_oe)
    );

    assign rdata = bank_q.rd;
endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         srst,
    input logic         wr_en,
    input logic         rd_en,
    input logic [1:0]   ptr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe
);
    AST_SRST_RELEASES_PADS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (pin_oe == '0)); // R10

    AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !srst) |=> $stable(rdata)); // R11

    AST_DIR_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd3 && !srst) |=> (pin_oe[W-1:1] == ~$past(wdata[W-1:1]))); // R3

    AST_PIN_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd0 && !srst) |=> ($stable(pin_oe) && $stable(pin_out))); // R6

    AST_OD_FLOATS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd1 && wdata[0] && !srst) |=> !pin_oe[0]); // R8
endmodule

bind gpio_regbank gpio_regbank_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ptr     (ptr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/tb_gpio_regbank.sv
module tb_gpio_regbank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       srst = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] ptr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    comparing = 0;
    bit    timed_out = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    gpio_regbank dut (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .rd_en(rd_en),
        .ptr(ptr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Reference model
    logic [7:0] m_out = 8'h00, m_pol = 8'hF0, m_dir = 8'hFF, m_rd = 8'h00;
    logic [7:0] m_pipe [$] = '{8'h00, 8'h00, 8'h00};

    task automatic model_defaults();
        m_out = 8'h00; m_pol = 8'hF0; m_dir = 8'hFF; m_rd = 8'h00;
        m_pipe = '{8'h00, 8'h00, 8'h00};
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || srst) begin
            model_defaults();
        end else begin
            logic [7:0] img;
            img = m_pipe[0];
            if (rd_en) begin
                case (ptr)
                    2'd0: m_rd = img ^ m_pol;
                    2'd1: m_rd = m_out;
                    2'd2: m_rd = m_pol;
                    default: m_rd = m_dir;
                endcase
            end
            if (wr_en) begin
                if (ptr == 2'd1) m_out = wdata;
                if (ptr == 2'd2) m_pol = wdata;
                if (ptr == 2'd3) m_dir = wdata;
            end
            m_pipe.push_back(pin_in);
            void'(m_pipe.pop_front());
        end
    end

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = (m_dir[i] == 1'b0);
            if (i == 0 && m_out[0]) r[i] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [7:0] r;
        r = m_out;
        r[0] = 1'b0;
        return r;
    endfunction

    task automatic check8(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            check8("rdata", rdata, m_rd);
            check8("pin_oe", pin_oe, exp_oe());
            check8("pin_out", pin_out, exp_out());
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic wr(logic [1:0] p, logic [7:0] d);
        wr_en = 1'b1; ptr = p; wdata = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] p);
        rd_en = 1'b1; ptr = p;
        cyc();
        rd_en = 1'b0;
        cyc();
    endtask

    task automatic run();
        tag = "R1";
        pin_in = 8'h3C;
        cyc(3);
        rst_n = 1'b1;
        comparing = 1;
        cyc(4);
        rd(2'd1); rd(2'd2); rd(2'd3);

        tag = "R3";
        wr(2'd1, 8'hA5);
        wr(2'd3, 8'h00);
        cyc(2);
        wr(2'd3, 8'h0F);
        cyc(2);

        tag = "R8";
        wr(2'd3, 8'h00);
        wr(2'd1, 8'hA4);
        cyc(2);
        wr(2'd1, 8'hFF);
        cyc();
        wr(2'd1, 8'hFE);
        wr(2'd3, 8'h01);
        cyc(2);

        tag = "R2";
        wr(2'd2, 8'h5A);
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);

        tag = "R7";
        wr(2'd1, 8'h0F);
        pin_in = 8'hF0;
        cyc(4);
        rd(2'd1);

        tag = "R4";
        pin_in = 8'h96;
        cyc();
        rd(2'd0);
        cyc(3);
        rd(2'd0);
        pin_in = 8'h69;
        cyc(4);
        rd(2'd0);

        tag = "R5";
        wr(2'd2, 8'h00); rd(2'd0);
        wr(2'd2, 8'hFF); rd(2'd0);
        wr(2'd2, 8'hF0); rd(2'd0);

        tag = "R6";
        wr(2'd0, 8'h55);
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);

        tag = "R11";
        rd_en = 1'b1; ptr = 2'd1;
        wr_en = 1'b1; wdata = 8'h33;
        cyc();
        wr_en = 1'b0; rd_en = 1'b0;
        cyc(3);
        rd(2'd1);

        tag = "R10";
        wr(2'd3, 8'h00);
        srst = 1'b1; wr_en = 1'b1; ptr = 2'd1; wdata = 8'hFF; rd_en = 1'b1;
        cyc();
        srst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cyc(2);
        rd(2'd2); rd(2'd3);

        tag = "R9";
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h11);
        wr(2'd1, 8'hC3);
        rd(2'd1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        #0.5;
        check8("async pin_oe", pin_oe, 8'h00);
        check8("async rdata", rdata, 8'h00);
        wr(2'd1, 8'hEE);
        cyc(2);
        rst_n = 1'b1;
        cyc(4);
        rd(2'd1); rd(2'd2); rd(2'd3);
        pin_in = 8'h81;
        cyc(4);
        rd(2'd0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule